// File: doc/BRIEF.md
# Receive Frame CRC Gate

This block sits behind the byte decoder of an Ethernet receiver. From the first byte after the start-of-frame delimiter it takes one byte per clock. Each accepted byte is written into a frame store and, in the same cycle, folded into a running CRC-32. No cycles are added for the CRC check, and the frame is never read back to verify it.

When the last byte of a frame arrives, the CRC register has already absorbed every data byte and the frame check sequence. The verdict is therefore known at that edge. A good frame is committed, and it becomes readable as a byte stream with first-byte and last-byte markers. A bad frame is erased by moving the speculative write pointer back to the committed one. A frame that meets a full store is also erased, and a wrapping overflow counter records it. Each stored byte carries two boundary flags, so the read side can rebuild the frame edges.

Top module: `rx_crc_gate`

## Requirements
- R1: While reset is asserted and just after it, `out_valid` is 0 and `ovf_count` is 0.
- R2: A frame opens on a byte with `in_valid` and `in_sof` high and closes on a byte with `in_valid` and `in_eof` high. A byte with `in_valid` high outside an open frame, and without `in_sof`, is ignored.
- R3: The check uses the reflected CRC-32 with polynomial 0xEDB88320. The register is set to 0xFFFFFFFF on every start byte and updated with every accepted byte, including the four FCS bytes. The FCS is the complement of the register and is sent least-significant byte first. A frame is good only if the register holds 0xDEBB20E3 after its end byte.
- R4: A good frame is delivered in arrival order. `out_sof` is high only on its first byte and `out_eof` only on its last. `out_valid` rises at the clock edge that samples the end byte, with no further latency.
- R5: A frame that fails the check produces no output byte and has no effect on the frames that follow it.
- R6: No byte of a frame is visible at the output before that frame has been committed.
- R7: The store holds 2^ADDR_W bytes. If a byte arrives while the store is full, its frame is dropped and `ovf_count` goes up by exactly 1 for that frame. Frames committed earlier are not affected.
- R8: A start byte that arrives inside an open frame discards the partial frame and opens a new one. This does not count as an overflow.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sof` and `out_eof` hold their values.
- R10: Writing one frame and reading an earlier one can run in the same cycles. All bytes are kept when frames arrive back to back, with no idle cycle between them.
- R11: A four-byte frame made only of an FCS over an empty payload (four 0x00 bytes) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame (final FCS byte) |
| in_data | input | 8 | Input byte |
| out_ready | input | 1 | Consumer takes the output byte this cycle |
| out_valid | output | 1 | A committed byte is presented |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte starts a frame |
| out_eof | output | 1 | Output byte ends a frame |
| ovf_count | output | CNT_W | Number of frames dropped because the store was full |

## Verification
The write side can commit a frame at the same edge where the read side pops the last byte of the frame before it. The fullness test can also run in a cycle where the consumer is freeing a slot. Both cases are provoked by sending several frames back to back with no idle cycle while the reader drains continuously. The delivered stream is then compared with the good frames in order, and the overflow count must stay unchanged. Overflow is provoked separately with the reader stalled, so that a committed frame occupies the store while a second frame outgrows the space left.

// File: rtl/rxcg_pkg.sv
package rxcg_pkg;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef struct packed {
    logic       first;
    logic       last;
    logic [7:0] data;
  } slot_t;
endpackage

// File: rtl/rxcg_crc8.sv
module rxcg_crc8
  import rxcg_pkg::*;
(
  input  logic [31:0] crc_in,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_out
);
  // eight unrolled shift-and-reduce stages, one per input bit
  logic [31:0] stage [0:8];

  assign stage[0] = crc_in ^ {24'd0, byte_in};

  for (genvar i = 0; i < 8; i++) begin : g_bit
    assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ CRC_POLY)
                                    : (stage[i] >> 1);
  end

  assign crc_out = stage[8];
endmodule

// File: rtl/rxcg_store.sv
module rxcg_store
  import rxcg_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  restart,
  input  logic  commit,
  input  logic  rewind,
  input  slot_t wr_slot,
  output logic  room,
  input  logic  rd_pop,
  output logic  rd_avail,
  output slot_t rd_slot
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  slot_t mem [DEPTH];

  logic [PTR_W-1:0] spec_q, com_q, rd_q;
  logic [PTR_W-1:0] spec_base, spec_add, spec_d, com_d, rd_d;
  logic             spec_en, com_en, rd_en;

  always_comb begin
    spec_base = restart ? com_q : spec_q;
    spec_add  = spec_base + PTR_W'(wr_en);
    room      = (spec_base - rd_q) != PTR_W'(DEPTH);
    spec_d    = rewind ? com_q : spec_add;
    spec_en   = wr_en | restart | rewind;
    com_d     = spec_add;
    com_en    = commit;
    rd_avail  = rd_q != com_q;
    rd_d      = rd_q + PTR_W'(1);
    rd_en     = rd_pop & rd_avail;
    rd_slot   = mem[rd_q[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[spec_base[ADDR_W-1:0]] <= wr_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_q <= '0;
      com_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (spec_en) spec_q <= spec_d;
      if (com_en)  com_q  <= com_d;
      if (rd_en)   rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/rx_crc_gate.sv
module rx_crc_gate
  import rxcg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [CNT_W-1:0] ovf_count
);
  logic             in_frame_q, in_frame_d;
  logic             bad_q, bad_d;
  logic [31:0]      crc_q, crc_base, crc_nx;
  logic [CNT_W-1:0] cnt_d;
  logic             start, take, bad_now, ovf_hit, frame_bad, last;
  logic             wr_en, commit, rewind, room, state_en;
  slot_t            wr_slot, rd_slot;

  rxcg_crc8 u_crc (
    .crc_in  (crc_base),
    .byte_in (in_data),
    .crc_out (crc_nx)
  );

  rxcg_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .restart  (start),
    .commit   (commit),
    .rewind   (rewind),
    .wr_slot  (wr_slot),
    .room     (room),
    .rd_pop   (out_ready),
    .rd_avail (out_valid),
    .rd_slot  (rd_slot)
  );

  always_comb begin
    start     = in_valid & in_sof;
    take      = in_valid & (in_sof | in_frame_q);
    crc_base  = start ? CRC_INIT : crc_q;
    bad_now   = start ? 1'b0 : bad_q;
    ovf_hit   = take & ~room & ~bad_now;
    frame_bad = bad_now | ovf_hit;
    wr_en     = take & ~frame_bad;
    last      = take & in_eof;
    commit    = last & ~frame_bad & (crc_nx == CRC_RESIDUE);
    rewind    = last & ~commit;
    wr_slot   = '{first: in_sof, last: in_eof, data: in_data};
    in_frame_d = ~in_eof;
    bad_d     = frame_bad & ~in_eof;
    cnt_d     = ovf_count + CNT_W'(1);
    state_en  = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      bad_q      <= 1'b0;
      crc_q      <= CRC_INIT;
      ovf_count  <= '0;
    end else begin
      if (state_en) begin
        in_frame_q <= in_frame_d;
        bad_q      <= bad_d;
        crc_q      <= crc_nx;
      end
      if (ovf_hit) ovf_count <= cnt_d;
    end
  end

  assign out_data = rd_slot.data;
  assign out_sof  = rd_slot.first;
  assign out_eof  = rd_slot.last;
endmodule

// File: rtl/rx_crc_gate_chk.sv
module rx_crc_gate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic [CNT_W-1:0] ovf_count
);
  logic at_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) at_head <= 1'b1;
    else if (out_valid && out_ready) at_head <= out_eof;
  end

  // R7: counter moves by at most one per cycle
  assert_ovf_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> (ovf_count == $past(ovf_count) + CNT_W'(1)));

  // R9: a stalled output holds
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                  && $stable(out_sof) && $stable(out_eof)));

  // R6: the store becomes non-empty only through an end byte
  assert_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_eof));

  // R4: first byte after a frame end carries the start flag, no other does
  assert_sof_place_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == at_head));
endmodule

bind rx_crc_gate rx_crc_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_eof    (in_eof),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .ovf_count (ovf_count)
);

// File: tb/sim_rx_crc_gate.sv
module sim_rx_crc_gate;
  localparam int AW = 6;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_sof, in_eof;
  logic [7:0]    in_data;
  logic          out_ready;
  logic          out_valid, out_sof, out_eof;
  logic [7:0]    out_data;
  logic [CW-1:0] ovf_count;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic rx_en = 1'b0;

  logic [7:0] fr[$];
  logic [9:0] got[$];
  logic [9:0] expq[$];

  always #5 clk = ~clk;

  rx_crc_gate #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .ovf_count(ovf_count)
  );

  always @(negedge clk) begin
    if (rx_en && out_valid) begin
      got.push_back({out_sof, out_eof, out_data});
      out_ready = 1'b1;
    end else begin
      out_ready = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  // bit-serial reference, independent of the byte-wide form
  task automatic mk_frame(input int n, input int seed);
    logic [31:0] c;
    logic fb;
    fr.delete();
    for (int i = 0; i < n; i++) fr.push_back(8'(seed * 7 + i * 13 + 1));
    c = 32'hFFFFFFFF;
    foreach (fr[i]) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ fr[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fr.push_back(c[8*k +: 8]);
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send(input bit good, input bit gap);
    for (int i = 0; i < fr.size(); i++) begin
      put(fr[i], i == 0, i == fr.size() - 1);
      if (good) expq.push_back({i == 0, i == fr.size() - 1, fr[i]});
    end
    if (gap) idle();
  endtask

  task automatic drain(input int n);
    @(posedge clk); rx_en = 1'b1;
    repeat (n) @(posedge clk);
    rx_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    chk(got.size() == expq.size(), {req, " byte count"}, got.size(), expq.size());
    if (got.size() == expq.size()) begin
      for (int i = 0; i < got.size(); i++) begin
        if (got[i] != expq[i]) begin
          chk(1'b0, {req, " byte"}, got[i], expq[i]);
          break;
        end
      end
    end
    got.delete(); expq.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(ovf_count == '0, "R1 ovf_count", ovf_count, 0);
  endtask

  task automatic t_good();
    logic [7:0] d0;
    mk_frame(20, 1);
    for (int i = 0; i < fr.size(); i++) begin
      put(fr[i], i == 0, i == fr.size() - 1);
      expq.push_back({i == 0, i == fr.size() - 1, fr[i]});
      if (i == fr.size() - 1) chk(out_valid == 1'b0, "R6 not visible before commit", out_valid, 0);
    end
    idle();
    chk(out_valid == 1'b1, "R4 visible right after end byte", out_valid, 1);
    d0 = out_data;
    repeat (3) @(negedge clk);
    chk(out_data == d0 && out_sof && out_valid, "R9 held while stalled", out_data, d0);
    drain(40);
    cmp_stream("R3 R4 good frame");
  endtask

  task automatic t_bad();
    mk_frame(15, 2);
    fr[3] = fr[3] ^ 8'h10;
    send(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R5 bad frame hidden", out_valid, 0);
    mk_frame(9, 3);
    send(1'b1, 1'b1);
    drain(30);
    cmp_stream("R5 following frame");
  endtask

  task automatic t_stray();
    for (int i = 0; i < 5; i++) put(8'hA0 + 8'(i), 1'b0, i == 4);
    idle();
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R2 stray bytes ignored", out_valid, 0);
    mk_frame(6, 4);
    send(1'b1, 1'b1);
    drain(20);
    cmp_stream("R2 frame after stray bytes");
  endtask

  task automatic t_restart();
    mk_frame(10, 5);
    for (int i = 0; i < 6; i++) put(fr[i], i == 0, 1'b0);
    mk_frame(12, 6);
    send(1'b1, 1'b1);
    drain(30);
    cmp_stream("R8 restart");
    chk(ovf_count == '0, "R8 no overflow count", ovf_count, 0);
  endtask

  task automatic t_overflow();
    mk_frame(30, 7);
    send(1'b1, 1'b1);
    mk_frame(36, 8);
    send(1'b0, 1'b1);
    chk(ovf_count == CW'(1), "R7 overflow counted once", ovf_count, 1);
    drain(50);
    cmp_stream("R7 committed frame intact");
    mk_frame(50, 9);
    send(1'b1, 1'b1);
    drain(70);
    cmp_stream("R7 store usable after drop");
    chk(ovf_count == CW'(1), "R7 count unchanged", ovf_count, 1);
  endtask

  task automatic t_concurrent();
    @(posedge clk); rx_en = 1'b1;
    for (int f = 0; f < 3; f++) begin
      mk_frame(30, 10 + f);
      send(1'b1, f == 2);
    end
    repeat (50) @(posedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    cmp_stream("R10 back to back with reading");
    chk(ovf_count == CW'(1), "R10 no new overflow", ovf_count, 1);
  endtask

  task automatic t_empty();
    mk_frame(0, 0);
    chk(fr[0] == 8'h00 && fr[3] == 8'h00, "R11 reference FCS", fr[0], 0);
    send(1'b1, 1'b1);
    drain(10);
    cmp_stream("R11 empty payload");
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    t_reset();
    t_good();
    t_bad();
    t_stray();
    t_restart();
    t_overflow();
    t_concurrent();
    t_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule